// File: doc/BRIEF.md
# Strided Vector Load Unit

This block fills one vector register from a word-addressed memory split across interleaved banks. A caller hands it a base word address, a signed stride and an element count through a start handshake. The unit then walks the address sequence `base`, `base+stride`, `base+2*stride`, ... and offers one request per clock to whichever bank owns the current word. Each bank stays occupied for a fixed number of cycles after it takes a request, and each read returns after a fixed latency. The returned words are written into the vector register in element order, and a one-cycle completion pulse follows the final write.

The banks are modelled inside the block as read-only storage preloaded with a fixed pattern, so the data a load returns depends only on the address. Requests always go out in element order. When the bank for the next element is still occupied, issue waits and no later element is sent ahead of it. The stride therefore sets the throughput. A stride that shares no factor with the bank count reaches one element per clock. A stride equal to the bank count sends every element to the same bank and waits out the full busy time between elements. The request strobe and the selected bank are brought out so that the schedule can be observed.

Top module: `vld_strided_load`

## Requirements
- R1: Element i is read from word address (base + i*stride) mod 2^16, with the stride taken as a signed 16-bit value. The word stored at address a is {a XOR 16'hC35A, a + 16'h1234} (upper half, lower half).
- R2: A request for word address a goes to bank a[3:0], and `req_bank` shows that bank in the cycle that `req_valid` is high.
- R3: A bank that takes a request in cycle t takes no further request before cycle t+4.
- R4: Requests leave in increasing element order, at most one per cycle. If the bank of the next element is busy, issue waits, and it proceeds in the first cycle that bank is free.
- R5: The word for the request issued in cycle t appears on the vector-register write port in cycle t+12, with `vr_idx` equal to the element number.
- R6: With a stride whose bank sequence never revisits a bank within 4 cycles (any odd stride, for example), the first request goes out in the cycle after the start is accepted and the remaining requests follow in consecutive cycles.
- R7: With a stride of 16, every element maps to one bank and consecutive requests are exactly 4 cycles apart.
- R8: `done` is high for exactly one cycle, in the cycle after the last element is written. `start_ready` is high again in that same cycle.
- R9: A start with a vector length of 0 sends no bank request and writes nothing, and `done` pulses in the cycle after the start is accepted.
- R10: While a load is in progress, `start_ready` is low and `start_valid` has no effect on the running load's requests or writes.
- R11: During and directly after reset, `start_ready` is 1 and `done`, `vr_we` and `req_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_valid | input | 1 | Start request |
| start_ready | output | 1 | Unit idle; start taken when both high |
| base_addr | input | 16 | Word address of element 0 |
| stride | input | 16 | Signed element-to-element address step |
| vec_len | input | 6 | Number of elements (0 to 32) |
| req_valid | output | 1 | A bank request is issued this cycle |
| req_bank | output | 4 | Bank addressed by that request |
| vr_we | output | 1 | Vector register write strobe |
| vr_idx | output | 5 | Element index being written |
| vr_data | output | 32 | Word written to that element |
| done | output | 1 | One-cycle completion pulse |

## Verification
Call the cycle after the start is accepted cycle 1. For every load, the bench computes each element's issue cycle with its own schedule of bank free times: an element issues no earlier than one cycle after its predecessor and no earlier than the cycle its bank frees. From that schedule it expects each write exactly 12 cycles after the element's issue and the done pulse one cycle after the last write. Outputs are sampled on the falling edge, and for every cycle the bench compares the request strobe and bank with the schedule, so a write or a request that arrives one cycle early or late is counted as a failure.

// File: rtl/vld_pkg.sv
package vld_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_DRAIN = 2'd2
    } ld_state_e;

    // Preloaded bank contents: a pure function of the word address.
    function automatic logic [DATA_W-1:0] bank_word(input logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] hi;
        logic [ADDR_W-1:0] lo;
        hi = a ^ 16'hC35A;
        lo = a + 16'h1234;
        return {hi, lo};
    endfunction

endpackage

// File: rtl/vld_addr_gen.sv
module vld_addr_gen
    import vld_pkg::*;
#(
    parameter int MAX_VL = 32,
    localparam int VL_W  = $clog2(MAX_VL + 1),
    localparam int IDX_W = $clog2(MAX_VL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] stride_i,
    input  logic [VL_W-1:0]   vl_i,
    input  logic              step_i,
    output logic [ADDR_W-1:0] cur_addr_o,
    output logic [IDX_W-1:0]  cur_idx_o,
    output logic              more_o,
    output logic              last_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] step;
        logic [IDX_W-1:0]  idx;
        logic [VL_W-1:0]   left;
    } gen_t;

    gen_t gen_d, gen_q;

    always_comb begin
        gen_d = gen_q;
        if (load_i) begin
            gen_d.addr = base_i;
            gen_d.step = stride_i;
            gen_d.idx  = '0;
            gen_d.left = vl_i;
        end else if (step_i && (gen_q.left != '0)) begin
            gen_d.addr = gen_q.addr + gen_q.step;   // wraps mod 2^16
            gen_d.idx  = gen_q.idx + 1'b1;
            gen_d.left = gen_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gen_q <= '0;
        else        gen_q <= gen_d;
    end

    assign cur_addr_o = gen_q.addr;
    assign cur_idx_o  = gen_q.idx;
    assign more_o     = (gen_q.left != '0);
    assign last_o     = (gen_q.left == VL_W'(1));

endmodule

// File: rtl/vld_bank_timers.sv
module vld_bank_timers #(
    parameter int NUM_BANKS  = 16,
    parameter int BUSY_CYC   = 4,
    localparam int BANK_W    = $clog2(NUM_BANKS),
    localparam int CNT_W     = $clog2(BUSY_CYC + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_i,
    input  logic [BANK_W-1:0]    bank_i,
    output logic [NUM_BANKS-1:0] free_o
);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [CNT_W-1:0] cnt_d, cnt_q;

        always_comb begin
            if (req_i && (bank_i == BANK_W'(b)))
                cnt_d = CNT_W'(BUSY_CYC - 1);
            else if (cnt_q != '0)
                cnt_d = cnt_q - 1'b1;
            else
                cnt_d = cnt_q;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt_q <= '0;
            else        cnt_q <= cnt_d;
        end

        assign free_o[b] = (cnt_q == '0);
    end

endmodule

// File: rtl/vld_return_pipe.sv
module vld_return_pipe
    import vld_pkg::*;
#(
    parameter int LAT_CYC = 12,
    parameter int IDX_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid_i,
    input  logic [IDX_W-1:0]  in_idx_i,
    input  logic [ADDR_W-1:0] in_addr_i,
    output logic              out_valid_o,
    output logic [IDX_W-1:0]  out_idx_o,
    output logic [DATA_W-1:0] out_data_o
);

    typedef struct packed {
        logic              vld;
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] addr;
    } stage_t;

    stage_t [LAT_CYC-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0].vld  = in_valid_i;
        pipe_d[0].idx  = in_idx_i;
        pipe_d[0].addr = in_addr_i;
        for (int k = 1; k < LAT_CYC; k++) pipe_d[k] = pipe_q[k-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign out_valid_o = pipe_q[LAT_CYC-1].vld;
    assign out_idx_o   = pipe_q[LAT_CYC-1].idx;
    assign out_data_o  = bank_word(pipe_q[LAT_CYC-1].addr);

endmodule

// File: rtl/vld_strided_load.sv
module vld_strided_load
    import vld_pkg::*;
#(
    parameter int NUM_BANKS = 16,
    parameter int BUSY_CYC  = 4,
    parameter int LAT_CYC   = 12,
    parameter int MAX_VL    = 32,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int VL_W     = $clog2(MAX_VL + 1),
    localparam int IDX_W    = $clog2(MAX_VL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_valid,
    output logic              start_ready,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [ADDR_W-1:0] stride,
    input  logic [VL_W-1:0]   vec_len,
    output logic              req_valid,
    output logic [BANK_W-1:0] req_bank,
    output logic              vr_we,
    output logic [IDX_W-1:0]  vr_idx,
    output logic [DATA_W-1:0] vr_data,
    output logic              done
);

    typedef struct packed {
        ld_state_e       st;
        logic [VL_W-1:0] wr_left;
        logic            done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                 accept;
    logic                 issue;
    logic [ADDR_W-1:0]    cur_addr;
    logic [IDX_W-1:0]     cur_idx;
    logic                 more;
    logic                 last;
    logic [BANK_W-1:0]    cur_bank;
    logic [NUM_BANKS-1:0] bank_free;
    logic                 ret_valid;

    assign accept   = (ctl_q.st == ST_IDLE) && start_valid;
    assign cur_bank = cur_addr[BANK_W-1:0];
    assign issue    = (ctl_q.st == ST_ISSUE) && more && bank_free[cur_bank];

    vld_addr_gen #(.MAX_VL(MAX_VL)) u_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (accept),
        .base_i     (base_addr),
        .stride_i   (stride),
        .vl_i       (vec_len),
        .step_i     (issue),
        .cur_addr_o (cur_addr),
        .cur_idx_o  (cur_idx),
        .more_o     (more),
        .last_o     (last)
    );

    vld_bank_timers #(.NUM_BANKS(NUM_BANKS), .BUSY_CYC(BUSY_CYC)) u_timers (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (issue),
        .bank_i (cur_bank),
        .free_o (bank_free)
    );

    vld_return_pipe #(.LAT_CYC(LAT_CYC), .IDX_W(IDX_W)) u_ret (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid_i  (issue),
        .in_idx_i    (cur_idx),
        .in_addr_i   (cur_addr),
        .out_valid_o (ret_valid),
        .out_idx_o   (vr_idx),
        .out_data_o  (vr_data)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (accept) begin
                    if (vec_len == '0) begin
                        ctl_d.done = 1'b1;
                    end else begin
                        ctl_d.st      = ST_ISSUE;
                        ctl_d.wr_left = vec_len;
                    end
                end
            end
            ST_ISSUE: begin
                if (issue && last) ctl_d.st = ST_DRAIN;
            end
            ST_DRAIN: ;
            default: ctl_d.st = ST_IDLE;
        endcase
        if (ret_valid && (ctl_q.st != ST_IDLE)) begin
            ctl_d.wr_left = ctl_q.wr_left - 1'b1;
            if (ctl_q.wr_left == VL_W'(1)) begin
                ctl_d.st   = ST_IDLE;
                ctl_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st      <= ST_IDLE;
            ctl_q.wr_left <= '0;
            ctl_q.done    <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign start_ready = (ctl_q.st == ST_IDLE);
    assign req_valid   = issue;
    assign req_bank    = cur_bank;
    assign vr_we       = ret_valid;
    assign done        = ctl_q.done;

endmodule

// File: rtl/vld_strided_load_chk.sv
module vld_strided_load_chk #(
    parameter int NUM_BANKS = 16,
    parameter int BUSY_CYC  = 4,
    parameter int MAX_VL    = 32,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int VL_W     = $clog2(MAX_VL + 1),
    localparam int IDX_W    = $clog2(MAX_VL),
    localparam int GAP_W    = $clog2(BUSY_CYC + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_valid,
    input logic              start_ready,
    input logic [VL_W-1:0]   vec_len,
    input logic              req_valid,
    input logic [BANK_W-1:0] req_bank,
    input logic              vr_we,
    input logic [IDX_W-1:0]  vr_idx,
    input logic              done
);

    // Cycles since each bank last took a request, saturating at BUSY_CYC.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_gap
        logic [GAP_W-1:0] gap_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                gap_q <= GAP_W'(BUSY_CYC);
            else if (req_valid && (req_bank == BANK_W'(b)))
                gap_q <= GAP_W'(1);
            else if (gap_q < GAP_W'(BUSY_CYC))
                gap_q <= gap_q + 1'b1;
        end

        a_r3_bank_busy: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && (req_bank == BANK_W'(b))) |-> (gap_q >= GAP_W'(BUSY_CYC)));
    end

    // Expected element number of the next write.
    logic [IDX_W-1:0] next_wr_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       next_wr_q <= '0;
        else if (start_valid && start_ready) next_wr_q <= '0;
        else if (vr_we)                   next_wr_q <= next_wr_q + 1'b1;
    end

    a_r4_write_order: assert property (@(posedge clk) disable iff (!rst_n)
        vr_we |-> (vr_idx == next_wr_q));

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_done_ready: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> start_ready);

    a_r10_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (start_valid && start_ready && (vec_len != '0)) |=> !start_ready);

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        start_ready |-> (!req_valid && !vr_we));

endmodule

bind vld_strided_load vld_strided_load_chk #(
    .NUM_BANKS (NUM_BANKS),
    .BUSY_CYC  (BUSY_CYC),
    .MAX_VL    (MAX_VL)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_valid (start_valid),
    .start_ready (start_ready),
    .vec_len     (vec_len),
    .req_valid   (req_valid),
    .req_bank    (req_bank),
    .vr_we       (vr_we),
    .vr_idx      (vr_idx),
    .done        (done)
);

// File: tb/vld_strided_load_tb.sv
module vld_strided_load_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_valid = 1'b0;
    logic        start_ready;
    logic [15:0] base_addr = '0;
    logic [15:0] stride = '0;
    logic [5:0]  vec_len = '0;
    logic        req_valid;
    logic [3:0]  req_bank;
    logic        vr_we;
    logic [4:0]  vr_idx;
    logic [31:0] vr_data;
    logic        done;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;   // 125 MHz

    vld_strided_load u_dut (
        .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
        .base_addr(base_addr), .stride(stride), .vec_len(vec_len),
        .req_valid(req_valid), .req_bank(req_bank), .vr_we(vr_we),
        .vr_idx(vr_idx), .vr_data(vr_data), .done(done)
    );

    localparam int NV = 8;
    // Row tags: R6 stride 1; R6 stride 3; R7 stride 16; R1 wrap past 16'hFFFF;
    // R1 negative stride; R4 stride 2; R4 stride 4; R4 stride 8 (two banks, stalls).
    localparam logic [15:0] T_BASE   [NV] = '{16'h0100, 16'h0FF0, 16'h2000, 16'hFFFE,
                                              16'h1234, 16'h0040, 16'h0000, 16'h0003};
    localparam logic [15:0] T_STRIDE [NV] = '{16'd1, 16'd3, 16'd16, 16'd5,
                                              16'hFFFF, 16'd2, 16'd4, 16'd8};
    localparam int          T_LEN    [NV] = '{16, 20, 6, 8, 12, 10, 12, 7};

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] word_at(input logic [15:0] a);
        return {a ^ 16'hC35A, a + 16'h1234};   // R1 contents
    endfunction

    task automatic run_load(input logic [15:0] b, input logic [15:0] s, input int n,
                            input bit poke);
        int          exp_t [32];
        logic [15:0] exp_a [32];
        int          free_at [16];
        int          t;
        int          seen;
        int          k;
        int          last_t;
        bit          fin;
        for (int j = 0; j < 16; j++) free_at[j] = 0;
        t = 0;
        for (int i = 0; i < n; i++) begin
            exp_a[i] = b + 16'(i) * s;
            t = t + 1;
            if (free_at[exp_a[i][3:0]] > t) t = free_at[exp_a[i][3:0]];
            free_at[exp_a[i][3:0]] = t + 4;
            exp_t[i] = t;
        end
        last_t = (n == 0) ? 1 : exp_t[n-1] + 13;

        @(negedge clk);
        chk(start_ready == 1'b1, "R8 ready before start", longint'(start_ready), 1);
        start_valid = 1'b1; base_addr = b; stride = s; vec_len = 6'(n);
        @(posedge clk);
        @(negedge clk);
        start_valid = 1'b0;
        seen = 0; fin = 1'b0; k = 1;
        while (!fin && k < 400) begin
            int want;
            want = -1;
            for (int i = 0; i < n; i++) if (exp_t[i] == k) want = i;
            // R2 R4 R6 R7 R9: request strobe and bank match the schedule
            chk(req_valid == (want >= 0), "R4 request timing", longint'(req_valid),
                longint'(want >= 0));
            if (want >= 0)
                chk(req_bank == exp_a[want][3:0], "R2 bank select", longint'(req_bank),
                    longint'(exp_a[want][3:0]));
            if (poke && k == 3) begin
                chk(start_ready == 1'b0, "R10 ready low while busy", longint'(start_ready), 0);
                start_valid = 1'b1; base_addr = 16'h7777; stride = 16'd1; vec_len = 6'd3;
            end
            if (poke && k == 6) start_valid = 1'b0;
            if (vr_we) begin
                if (seen < n) begin
                    chk(vr_idx == 5'(seen), "R5 element index", longint'(vr_idx), seen);
                    chk(vr_data == word_at(exp_a[seen]), "R1 data", longint'(vr_data),
                        longint'(word_at(exp_a[seen])));
                    chk(k == exp_t[seen] + 12, "R5 return latency", k, exp_t[seen] + 12);
                end else begin
                    chk(1'b0, "R9 unexpected write", seen, n);
                end
                seen++;
            end
            if (done) begin
                fin = 1'b1;
                chk(k == last_t, "R8 done timing", k, last_t);
                chk(seen == n, "R8 write count", seen, n);
                chk(start_ready == 1'b1, "R8 ready with done", longint'(start_ready), 1);
            end else begin
                @(posedge clk);
                @(negedge clk);
                k++;
            end
        end
        if (!fin) chk(1'b0, "R8 done missing", k, last_t);
        @(posedge clk);
        @(negedge clk);
        chk(done == 1'b0, "R8 done one cycle", longint'(done), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R11: reset state
        repeat (3) @(negedge clk);
        chk(start_ready == 1'b1, "R11 ready in reset", longint'(start_ready), 1);
        chk({done, vr_we, req_valid} == 3'b000, "R11 quiet in reset",
            longint'({done, vr_we, req_valid}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({start_ready, done, vr_we, req_valid} == 4'b1000, "R11 after reset",
            longint'({start_ready, done, vr_we, req_valid}), 8);

        // Table walk: R1 R2 R3 R4 R5 R6 R7
        for (int r = 0; r < NV; r++) run_load(T_BASE[r], T_STRIDE[r], T_LEN[r], 1'b0);

        // R9: zero length completes at once with no request
        run_load(16'h0500, 16'd1, 0, 1'b0);
        // R10: start pulsed during a long stride-16 load has no effect
        run_load(16'h3000, 16'd16, 5, 1'b1);
        // Full-length load at the boundary of the element count
        run_load(16'hFFF0, 16'd7, 32, 1'b0);
        // Back-to-back zero-length then normal load
        run_load(16'h0000, 16'd0, 0, 1'b0);
        run_load(16'h4321, 16'd0, 3, 1'b0);   // stride 0: same bank, R3 spacing

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule